// File: doc/BRIEF.md
# Dual-Source CPU Interrupt Gate

This block gathers interrupt events from two places, a general interrupt controller and a DMA controller, and turns them into two independent exception requests for a processor core. Each source keeps a sticky status vector. An event pulse on an input line latches its bit. Software clears the bit by writing a one to it. Each source also has a mask vector, and a request is raised only for status bits whose mask bit is set.

The two requests are qualified by the processor's own status word. The general request needs the interrupt-enable bit at position 10. The DMA request needs an exact pattern over a wider group of status bits, and it also needs the DMA controller's master enable. The DMA side keeps its status and its mask in one 32-bit register view: status in the low half, mask in the high half. Its top status bit raises a request even when every mask bit is clear. Each request comes with a fixed vector offset. A one-cycle strobe tells the timers to capture their hold values when the general request comes up while general status bit 1 is set.

Top module: `irq_req_gate`

## Requirements
- R1: After reset, all status and mask bits read as zero, and `gen_req_o`, `dma_req_o` and `hold_strobe_o` are low.
- R2: A one-cycle pulse on bit n of `gen_set_i` or `dma_set_i` sets bit n of the matching status vector at the next clock edge. The bit stays set until software clears it.
- R3: A write to select 0 clears each general status bit whose write-data bit is 1. A write to select 2 does the same for DMA status bits using write-data bits [15:0]. Write-data bits that are 0 leave status unchanged. If a set pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A write to select 1 loads the general mask from write-data [15:0]. A write to select 2 loads the DMA mask from write-data [31:16]. Reads return the following: select 0 gives `{16'h0, general status}`, select 1 gives `{16'h0, general mask}`, select 2 gives `{DMA mask, DMA status}`, and select 3 gives zero.
- R5: `gen_req_o` is registered. It is high in the cycle after an edge where `cpu_status_i[10]` was 1 and (general status AND general mask) was nonzero. Otherwise it is low.
- R6: `dma_req_o` is high only after an edge where (`cpu_status_i` AND 0x0001_0807) equalled exactly 0x0001_0801.
- R7: Given the R6 condition and the enable in R8, `dma_req_o` rises when (DMA mask AND DMA status) is nonzero. It also rises when DMA status bit 15 is set, whatever the mask holds.
- R8: When `dma_master_en_i` is 0 at an edge, `dma_req_o` is low in the following cycle.
- R9: `gen_vec_o` always reads 12'h400 and `dma_vec_o` always reads 12'h800.
- R10: `hold_strobe_o` is high for exactly one cycle when `gen_req_o` goes from low to high while general status bit 1 was set at that edge. It is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_set_i | input | 16 | Per-bit event pulses from the general controller |
| dma_set_i | input | 16 | Per-channel event pulses from the DMA controller |
| cpu_status_i | input | 32 | Processor status word |
| dma_master_en_i | input | 1 | DMA controller master enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 general status, 1 general mask, 2 DMA combined) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_sel_i` |
| gen_req_o | output | 1 | General exception request |
| gen_vec_o | output | 12 | General vector offset |
| dma_req_o | output | 1 | DMA exception request |
| dma_vec_o | output | 12 | DMA vector offset |
| hold_strobe_o | output | 1 | Timer hold capture strobe |

## Verification
The assertions assume that the set pulses, the processor status word, the master enable and the register controls are all stable around each rising edge and are driven to known values throughout reset. The properties look one cycle back across those inputs. The stimulus changes every input only at the falling edge. It holds reset for several cycles with the inputs at zero. It keeps set pulses sparse and clear patterns sparse so that status bits live long enough to reach the request outputs. It biases the processor status word toward the exact enabling patterns and toward values that miss them by one bit.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    localparam int          CPU_W        = 32;
    localparam int          VEC_W        = 12;
    localparam int          GEN_EN_BIT   = 10;
    localparam logic [31:0] DMA_CHK_MASK = 32'h0001_0807;
    localparam logic [31:0] DMA_CHK_VAL  = 32'h0001_0801;
    localparam logic [11:0] GEN_VEC      = 12'h400;
    localparam logic [11:0] DMA_VEC      = 12'h800;

    typedef enum logic [1:0] {
        SEL_GEN_STAT = 2'd0,
        SEL_GEN_MASK = 2'd1,
        SEL_DMA      = 2'd2,
        SEL_NONE     = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask_o
);

    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] mask;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        // clear first, then set so that a simultaneous event survives
        bank_d.stat = (bank_q.stat & ~clr_i) | set_i;
        if (mask_we_i) begin
            bank_d.mask = mask_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign stat_o = bank_q.stat;
    assign mask_o = bank_q.mask;

endmodule

// File: rtl/irq_req_qual.sv
module irq_req_qual #(
    parameter int W         = 16,
    parameter bit HAS_FORCE = 1'b0
) (
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] mask_i,
    input  logic         cpu_ok_i,
    input  logic         src_en_i,
    output logic         hit_o
);

    logic masked_any;
    logic forced;

    assign masked_any = |(stat_i & mask_i);

    generate
        if (HAS_FORCE) begin : g_force
            assign forced = stat_i[W-1];
        end else begin : g_noforce
            assign forced = 1'b0;
        end
    endgenerate

    assign hit_o = cpu_ok_i & src_en_i & (masked_any | forced);

endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate
    import irq_gate_pkg::*;
#(
    parameter int GEN_W  = 16,
    parameter int DMA_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GEN_W-1:0]    gen_set_i,
    input  logic [DMA_W-1:0]    dma_set_i,
    input  logic [CPU_W-1:0]    cpu_status_i,
    input  logic                dma_master_en_i,
    input  logic                reg_we_i,
    input  logic [1:0]          reg_sel_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                gen_req_o,
    output logic [VEC_W-1:0]    gen_vec_o,
    output logic                dma_req_o,
    output logic [VEC_W-1:0]    dma_vec_o,
    output logic                hold_strobe_o
);

    localparam int GEN_PAD = DATA_W - GEN_W;

    typedef struct packed {
        logic gen_req;
        logic dma_req;
        logic strobe;
    } out_t;

    reg_sel_e sel;
    logic [GEN_W-1:0] gen_clr, gen_stat_w, gen_mask_w;
    logic [DMA_W-1:0] dma_clr, dma_stat_w, dma_mask_w;
    logic gen_mask_we, dma_mask_we;
    logic gen_cpu_ok, dma_cpu_ok, gen_hit, dma_hit;
    out_t out_d, out_q;

    assign sel = reg_sel_e'(reg_sel_i);

    // write decode
    always_comb begin
        gen_clr     = '0;
        dma_clr     = '0;
        gen_mask_we = 1'b0;
        dma_mask_we = 1'b0;
        if (reg_we_i) begin
            case (sel)
                SEL_GEN_STAT: gen_clr = reg_wdata_i[GEN_W-1:0];
                SEL_GEN_MASK: gen_mask_we = 1'b1;
                SEL_DMA: begin
                    dma_clr     = reg_wdata_i[DMA_W-1:0];
                    dma_mask_we = 1'b1;
                end
                default: ;
            endcase
        end
    end

    irq_status_bank #(.W(GEN_W)) u_gen_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (gen_set_i),
        .clr_i        (gen_clr),
        .mask_we_i    (gen_mask_we),
        .mask_wdata_i (reg_wdata_i[GEN_W-1:0]),
        .stat_o       (gen_stat_w),
        .mask_o       (gen_mask_w)
    );

    irq_status_bank #(.W(DMA_W)) u_dma_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (dma_set_i),
        .clr_i        (dma_clr),
        .mask_we_i    (dma_mask_we),
        .mask_wdata_i (reg_wdata_i[2*DMA_W-1:DMA_W]),
        .stat_o       (dma_stat_w),
        .mask_o       (dma_mask_w)
    );

    assign gen_cpu_ok = cpu_status_i[GEN_EN_BIT];
    assign dma_cpu_ok = ((cpu_status_i & DMA_CHK_MASK) == DMA_CHK_VAL);

    irq_req_qual #(.W(GEN_W), .HAS_FORCE(1'b0)) u_gen_qual (
        .stat_i   (gen_stat_w),
        .mask_i   (gen_mask_w),
        .cpu_ok_i (gen_cpu_ok),
        .src_en_i (1'b1),
        .hit_o    (gen_hit)
    );

    irq_req_qual #(.W(DMA_W), .HAS_FORCE(1'b1)) u_dma_qual (
        .stat_i   (dma_stat_w),
        .mask_i   (dma_mask_w),
        .cpu_ok_i (dma_cpu_ok),
        .src_en_i (dma_master_en_i),
        .hit_o    (dma_hit)
    );

    always_comb begin
        out_d         = out_q;
        out_d.gen_req = gen_hit;
        out_d.dma_req = dma_hit;
        out_d.strobe  = gen_hit & ~out_q.gen_req & gen_stat_w[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    // read mux
    always_comb begin
        case (sel)
            SEL_GEN_STAT: reg_rdata_o = {{GEN_PAD{1'b0}}, gen_stat_w};
            SEL_GEN_MASK: reg_rdata_o = {{GEN_PAD{1'b0}}, gen_mask_w};
            SEL_DMA:      reg_rdata_o = {dma_mask_w, dma_stat_w};
            default:      reg_rdata_o = '0;
        endcase
    end

    assign gen_req_o     = out_q.gen_req;
    assign dma_req_o     = out_q.dma_req;
    assign hold_strobe_o = out_q.strobe;
    assign gen_vec_o     = GEN_VEC;
    assign dma_vec_o     = DMA_VEC;

endmodule

// File: rtl/irq_req_gate_chk.sv
module irq_req_gate_chk
    import irq_gate_pkg::*;
#(
    parameter int GEN_W  = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [GEN_W-1:0]  gen_set_i,
    input logic [GEN_W-1:0]  gen_stat,
    input logic [CPU_W-1:0]  cpu_status_i,
    input logic              dma_master_en_i,
    input logic              reg_we_i,
    input logic [1:0]        reg_sel_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic              gen_req_o,
    input logic              dma_req_o,
    input logic              hold_strobe_o
);

    // R2
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_set_i[0] |=> gen_stat[0]);

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_sel_i == 2'd0 && reg_wdata_i[0] && !gen_set_i[0]) |=> !gen_stat[0]);

    // R5
    gen_cpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_req_o) |-> $past(cpu_status_i[GEN_EN_BIT]));

    // R6
    dma_cpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req_o) |-> $past((cpu_status_i & DMA_CHK_MASK) == DMA_CHK_VAL));

    // R8
    dma_master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_master_en_i |=> !dma_req_o);

    // R10
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_strobe_o |=> !hold_strobe_o);

    // R10
    strobe_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_strobe_o |-> gen_req_o);

endmodule

bind irq_req_gate irq_req_gate_chk #(.GEN_W(GEN_W), .DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .gen_set_i       (gen_set_i),
    .gen_stat        (gen_stat_w),
    .cpu_status_i    (cpu_status_i),
    .dma_master_en_i (dma_master_en_i),
    .reg_we_i        (reg_we_i),
    .reg_sel_i       (reg_sel_i),
    .reg_wdata_i     (reg_wdata_i),
    .gen_req_o       (gen_req_o),
    .dma_req_o       (dma_req_o),
    .hold_strobe_o   (hold_strobe_o)
);

// File: tb/sim_irq_req_gate.sv
module sim_irq_req_gate;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] gen_set, dma_set;
    logic [31:0] cpu_status;
    logic        dma_en;
    logic        we;
    logic [1:0]  sel;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        gen_req, dma_req, strobe;
    logic [11:0] gen_vec, dma_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] m_gstat, m_gmask, m_dstat, m_dmask;
    logic        m_greq, m_dreq, m_strobe;

    always #5 clk = ~clk;

    irq_req_gate u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .gen_set_i       (gen_set),
        .dma_set_i       (dma_set),
        .cpu_status_i    (cpu_status),
        .dma_master_en_i (dma_en),
        .reg_we_i        (we),
        .reg_sel_i       (sel),
        .reg_wdata_i     (wdata),
        .reg_rdata_o     (rdata),
        .gen_req_o       (gen_req),
        .gen_vec_o       (gen_vec),
        .dma_req_o       (dma_req),
        .dma_vec_o       (dma_vec),
        .hold_strobe_o   (strobe)
    );

    function automatic logic f_gen(input logic [15:0] s, input logic [15:0] m, input logic [31:0] c);
        return c[10] && ((s & m) != 16'h0);
    endfunction

    function automatic logic f_dma(input logic [15:0] s, input logic [15:0] m,
                                   input logic [31:0] c, input logic en);
        return en && ((c & 32'h0001_0807) == 32'h0001_0801) && (((s & m) != 16'h0) || s[15]);
    endfunction

    function automatic logic [31:0] f_read(input logic [1:0] a);
        case (a)
            2'd0:    return {16'h0, m_gstat};
            2'd1:    return {16'h0, m_gmask};
            2'd2:    return {m_dmask, m_dstat};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: model update from pre-edge state, then compare
    task automatic step();
        logic g, d, s;
        @(posedge clk);
        g = f_gen(m_gstat, m_gmask, cpu_status);
        d = f_dma(m_dstat, m_dmask, cpu_status, dma_en);
        s = g && !m_greq && m_gstat[1];
        m_greq = g; m_dreq = d; m_strobe = s;
        if (we && sel == 2'd0) m_gstat = m_gstat & ~wdata[15:0];
        if (we && sel == 2'd1) m_gmask = wdata[15:0];
        if (we && sel == 2'd2) begin
            m_dstat = m_dstat & ~wdata[15:0];
            m_dmask = wdata[31:16];
        end
        m_gstat = m_gstat | gen_set;
        m_dstat = m_dstat | dma_set;
        @(negedge clk);
        check("R5 gen_req", {31'h0, gen_req}, {31'h0, m_greq});
        check("R6 R7 R8 dma_req", {31'h0, dma_req}, {31'h0, m_dreq});
        check("R10 strobe", {31'h0, strobe}, {31'h0, m_strobe});
        check("R2 R3 R4 readback", rdata, f_read(sel));
    endtask

    task automatic idle();
        gen_set = '0; dma_set = '0; we = 1'b0; wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; idle(); sel = 2'd0; cpu_status = '0; dma_en = 1'b0;
        m_gstat = '0; m_gmask = '0; m_dstat = '0; m_dmask = '0;
        m_greq = 0; m_dreq = 0; m_strobe = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 gen_req", {31'h0, gen_req}, 32'h0);
        check("R1 dma_req", {31'h0, dma_req}, 32'h0);
        check("R1 strobe",  {31'h0, strobe}, 32'h0);
        for (int a = 0; a < 4; a++) begin
            sel = a[1:0]; #1;
            check("R1 readback", rdata, 32'h0);
        end
        // R9 vectors
        check("R9 gen_vec", {20'h0, gen_vec}, 32'h400);
        check("R9 dma_vec", {20'h0, dma_vec}, 32'h800);

        // R4 masks, R2 set, R10 strobe with bit 1
        sel = 2'd1; we = 1'b1; wdata = 32'h0000_0002; step(); idle();
        cpu_status = 32'h0000_0400;
        sel = 2'd0; gen_set = 16'h0002; step(); idle();
        check("R2 gen bit1 held", rdata, 32'h0000_0002);
        step();
        check("R10 strobe on rise", {31'h0, strobe}, 32'h1);
        step();
        check("R10 strobe single", {31'h0, strobe}, 32'h0);
        check("R5 gen_req held", {31'h0, gen_req}, 32'h1);
        // R5 cpu bit cleared blocks
        cpu_status = 32'h0; step();
        check("R5 cpu gate", {31'h0, gen_req}, 32'h0);
        // R3 set wins over clear
        we = 1'b1; sel = 2'd0; wdata = 32'h0000_0004; gen_set = 16'h0004; step(); idle();
        check("R3 set wins", rdata, 32'h0000_0006);
        we = 1'b1; wdata = 32'h0000_0006; step(); idle();
        check("R3 w1c clear", rdata, 32'h0);

        // R7 unmaskable bit 15 with zero mask
        sel = 2'd2; we = 1'b1; wdata = 32'h0; step(); idle();
        dma_en = 1'b1; cpu_status = 32'h0001_0801;
        dma_set = 16'h8000; step(); idle();
        step();
        check("R7 forced bit15", {31'h0, dma_req}, 32'h1);
        // R6 off-by-one pattern
        cpu_status = 32'h0001_0803; step();
        check("R6 pattern miss", {31'h0, dma_req}, 32'h0);
        // R8 master enable
        cpu_status = 32'h0001_0801; dma_en = 1'b0; step();
        check("R8 master off", {31'h0, dma_req}, 32'h0);
        dma_en = 1'b1;
        we = 1'b1; wdata = 32'h0000_8000; step(); idle();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int k;
            gen_set = ($urandom % 6 == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
            dma_set = ($urandom % 6 == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
            we      = ($urandom % 4 == 0);
            sel     = 2'($urandom % 4);
            wdata   = $urandom & $urandom & $urandom;
            dma_en  = ($urandom % 4 != 0);
            k = $urandom % 5;
            case (k)
                0: cpu_status = 32'h0000_0400 | ($urandom & 32'hFFFF_F000);
                1: cpu_status = 32'h0001_0801;
                2: cpu_status = 32'h0001_0C01;
                3: cpu_status = 32'h0001_0801 ^ (32'h1 << ($urandom % 17));
                default: cpu_status = $urandom;
            endcase
            step();
        end
        idle();
        check("R9 gen_vec end", {20'h0, gen_vec}, 32'h400);
        check("R9 dma_vec end", {20'h0, dma_vec}, 32'h800);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule